// File: doc/BRIEF.md
# Termination Calibration User-Mode Sequencer

This controller drives the user-mode control lines of a set of on-chip termination calibration engines and of the I/O banks that consume their results. A single start request, together with a mask of engines to calibrate and a mask of banks to refresh, launches a fixed sequence. The sequence raises a global calibration enable and pulses an active-low clear. It holds the select lines of all chosen engines for a calibration window. It then reads each chosen engine's result code serially, one engine at a time, and pulses an update strobe to every enabled bank fed by that engine. The analog calibration and the I/O buffers lie outside the block.

The controller is a Moore machine with the states IDLE, LEAD, CAL, LAG, GAP, XFER, XGAP, DRAIN and DONE. IDLE moves to LEAD on a start with a non-zero engine mask, and the masks are captured at that moment. LEAD moves to CAL after one cycle. CAL moves to LAG after CAL_CYCLES cycles. LAG moves to GAP after one cycle. GAP moves to XFER after one cycle, picking the lowest pending engine. XFER moves to XGAP after CODE_BITS cycles. XGAP returns to XFER if engines are still pending and otherwise goes to DRAIN. DRAIN moves to DONE once no bank strobe is high. DONE returns to IDLE after one cycle.

Bank b is fed by engine b mod N_ENG. The strobe length is the smallest whole number of clocks covering UPD_MIN_PS at a clock period of CLK_PS, and never less than one clock. At the defaults of 25 ns and 5 ns this is 5 clocks.

Top module: `term_cal_seq`

## Requirements
- R1: After an accepted start, the first cycle has cal_en high, clr_n low and no select line high. clr_n is low for that one cycle only.
- R2: In the next CAL_CYCLES (default 1000) cycles, every select line whose engine_mask bit was set is high together, and all others are low. cal_en stays high.
- R3: cal_en stays high for exactly one cycle after the calibration selects fall. It is then low for exactly one cycle before the first transfer select rises, and stays low until the sequence ends.
- R4: Each chosen engine is selected alone, in ascending index order, for exactly CODE_BITS (default 28) cycles, with exactly one all-low cycle after each transfer pulse.
- R5: A select line whose engine_mask bit was clear is never high during the run.
- R6: For bank b with its bank_mask bit set and engine b mod N_ENG chosen, bank_upd[b] goes high in the cycle after that engine's transfer select falls. It stays high for UPD_CYC cycles, where UPD_CYC = max(1, ceil(UPD_MIN_PS / CLK_PS)), which is 5 at the defaults.
- R7: A bank whose bank_mask bit is clear, or whose feeding engine is not chosen, never sees its strobe high.
- R8: done is high for exactly one cycle, in the cycle after the first cycle at or after the end of the last transfer gap in which no strobe is high. All outputs are then idle.
- R9: A start received while a sequence is running is ignored, and the running sequence's timing is unchanged.
- R10: A start with an all-zero engine_mask is ignored, and all outputs stay idle.
- R11: During and after reset, cal_en=0, clr_n=1, eng_sel=0, bank_upd=0 and done=0.
- R12: The masks are captured when a start is accepted. Changes to engine_mask and bank_mask during a run have no effect on that run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled in IDLE |
| engine_mask | input | N_ENG | Engines to calibrate and read |
| bank_mask | input | N_BANK | Banks to refresh |
| cal_en | output | 1 | Global calibration enable |
| clr_n | output | 1 | Active-low clear pulse |
| eng_sel | output | N_ENG | Engine select lines |
| bank_upd | output | N_BANK | Per-bank parallel-update strobes |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench predicts every output in every cycle of each run from the masks alone, so a one-cycle error in the lead, lag or gap shows up as a mismatch. A window that is off by one, or that starts or stops at the wrong edge, fails in the same way. A run that selects non-adjacent engines and skips a bank checks the ordering and the engine-to-bank map. A design that picked engines in the wrong order or wired strobes to the wrong engine would raise the wrong strobe. A single-engine run with no enabled banks checks that done is not held back by a strobe that never fires. Mid-run pokes of start and of the masks, and a start with an empty engine mask, check that a careless design would not restart, change selects or leave idle.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LEAD,
        S_CAL,
        S_LAG,
        S_GAP,
        S_XFER,
        S_XGAP,
        S_DRAIN,
        S_DONE
    } tcs_state_e;

    function automatic int unsigned ceil_div_min1(input int unsigned num, input int unsigned den);
        int unsigned q;
        q = (num + den - 1) / den;
        return (q < 1) ? 1 : q;
    endfunction

endpackage

// File: rtl/tcs_pick.sv
module tcs_pick #(
    parameter int unsigned N  = 4,
    parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IW'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tcs_upd_gen.sv
module tcs_upd_gen #(
    parameter int unsigned N_ENG   = 4,
    parameter int unsigned N_BANK  = 4,
    parameter int unsigned UPD_CYC = 5,
    parameter int unsigned IW      = (N_ENG > 1) ? $clog2(N_ENG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [IW-1:0]     src_eng,
    input  logic [N_BANK-1:0] bank_en,
    output logic [N_BANK-1:0] upd,
    output logic              busy
);
    localparam int unsigned UW = $clog2(UPD_CYC + 1);

    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
        localparam int unsigned FEED = b % N_ENG;
        logic [UW-1:0] left;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                left <= '0;
            end else if (fire && bank_en[b] && (src_eng == IW'(FEED))) begin
                left <= UW'(UPD_CYC);
            end else if (left != '0) begin
                left <= left - 1'b1;
            end
        end

        assign upd[b] = (left != '0);
    end

    assign busy = |upd;
endmodule

// File: rtl/term_cal_seq.sv
module term_cal_seq
    import tcs_pkg::*;
#(
    parameter int unsigned N_ENG      = 4,
    parameter int unsigned N_BANK     = 4,
    parameter int unsigned CAL_CYCLES = 1000,
    parameter int unsigned CODE_BITS  = 28,
    parameter int unsigned CLK_PS     = 5000,
    parameter int unsigned UPD_MIN_PS = 25000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [N_ENG-1:0]  engine_mask,
    input  logic [N_BANK-1:0] bank_mask,
    output logic              cal_en,
    output logic              clr_n,
    output logic [N_ENG-1:0]  eng_sel,
    output logic [N_BANK-1:0] bank_upd,
    output logic              done
);
    localparam int unsigned UPD_CYC = ceil_div_min1(UPD_MIN_PS, CLK_PS);
    localparam int unsigned IW      = (N_ENG > 1) ? $clog2(N_ENG) : 1;
    localparam int unsigned MAXW    = (CAL_CYCLES > CODE_BITS) ? CAL_CYCLES : CODE_BITS;
    localparam int unsigned CW      = $clog2(MAXW + 1);

    tcs_state_e          state, state_nx;
    logic [CW-1:0]       cnt;
    logic [N_ENG-1:0]    eng_q;
    logic [N_BANK-1:0]   bank_q;
    logic [N_ENG-1:0]    pending;
    logic [IW-1:0]       cur;
    logic [IW-1:0]       pick_idx;
    logic                pick_any;
    logic                cal_last;
    logic                xfer_last;
    logic                upd_busy;

    assign cal_last  = (cnt == CW'(CAL_CYCLES - 1));
    assign xfer_last = (cnt == CW'(CODE_BITS - 1));

    tcs_pick #(.N(N_ENG), .IW(IW)) u_pick (
        .req (pending),
        .idx (pick_idx),
        .any (pick_any)
    );

    tcs_upd_gen #(
        .N_ENG   (N_ENG),
        .N_BANK  (N_BANK),
        .UPD_CYC (UPD_CYC),
        .IW      (IW)
    ) u_upd (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (state == S_XFER && xfer_last),
        .src_eng (cur),
        .bank_en (bank_q),
        .upd     (bank_upd),
        .busy    (upd_busy)
    );

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (start && (engine_mask != '0)) state_nx = S_LEAD;
            S_LEAD:  state_nx = S_CAL;
            S_CAL:   if (cal_last) state_nx = S_LAG;
            S_LAG:   state_nx = S_GAP;
            S_GAP:   state_nx = S_XFER;
            S_XFER:  if (xfer_last) state_nx = S_XGAP;
            S_XGAP:  state_nx = pick_any ? S_XFER : S_DRAIN;
            S_DRAIN: if (!upd_busy) state_nx = S_DONE;
            S_DONE:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // state register and sequencing data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            cnt     <= '0;
            eng_q   <= '0;
            bank_q  <= '0;
            pending <= '0;
            cur     <= '0;
        end else begin
            state <= state_nx;
            cnt   <= (state_nx != state) ? '0 : cnt + 1'b1;
            if (state == S_IDLE && state_nx == S_LEAD) begin
                eng_q   <= engine_mask;
                bank_q  <= bank_mask;
                pending <= engine_mask;
            end
            if (state_nx == S_XFER && state != S_XFER) begin
                cur <= pick_idx;
            end
            if (state == S_XFER && xfer_last) begin
                pending <= pending & ~(N_ENG'(1) << cur);
            end
        end
    end

    // Moore outputs
    always_comb begin
        cal_en  = 1'b0;
        clr_n   = 1'b1;
        eng_sel = '0;
        done    = 1'b0;
        unique case (state)
            S_LEAD: begin
                cal_en = 1'b1;
                clr_n  = 1'b0;
            end
            S_CAL: begin
                cal_en  = 1'b1;
                eng_sel = eng_q;
            end
            S_LAG:  cal_en = 1'b1;
            S_XFER: eng_sel = N_ENG'(1) << cur;
            S_DONE: done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/tcs_checker.sv
module tcs_checker #(
    parameter int unsigned N_ENG      = 4,
    parameter int unsigned N_BANK     = 4,
    parameter int unsigned CAL_CYCLES = 1000,
    parameter int unsigned CODE_BITS  = 28,
    parameter int unsigned UPD_CYC    = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cal_en,
    input logic              clr_n,
    input logic [N_ENG-1:0]  eng_sel,
    input logic [N_BANK-1:0] bank_upd,
    input logic              done
);
    logic [15:0] sel_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          sel_run <= '0;
        else if (|eng_sel)   sel_run <= sel_run + 1'b1;
        else                 sel_run <= '0;
    end

    AST_LEAD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(|eng_sel) && cal_en) |-> ($past(cal_en) && !$past(clr_n))); // R1

    AST_CLEAR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> clr_n); // R1

    AST_SEL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(|eng_sel) |-> (sel_run == 16'(CAL_CYCLES) || sel_run == 16'(CODE_BITS))); // R2

    AST_LAG_AFTER_CAL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cal_en) |-> ($past(eng_sel) == '0)); // R3

    AST_XFER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(|eng_sel) && !cal_en) |-> !$past(cal_en)); // R3

    AST_XFER_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_en |-> $onehot0(eng_sel)); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    for (genvar b = 0; b < N_BANK; b++) begin : g_upd
        logic [15:0] upd_run;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           upd_run <= '0;
            else if (bank_upd[b]) upd_run <= upd_run + 1'b1;
            else                  upd_run <= '0;
        end

        AST_UPD_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(bank_upd[b]) |-> (upd_run == 16'(UPD_CYC))); // R6
    end
endmodule

bind term_cal_seq tcs_checker #(
    .N_ENG      (N_ENG),
    .N_BANK     (N_BANK),
    .CAL_CYCLES (CAL_CYCLES),
    .CODE_BITS  (CODE_BITS),
    .UPD_CYC    (UPD_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cal_en   (cal_en),
    .clr_n    (clr_n),
    .eng_sel  (eng_sel),
    .bank_upd (bank_upd),
    .done     (done)
);

// File: tb/term_cal_seq_tb.sv
module term_cal_seq_tb;
    localparam int NE   = 4;
    localparam int NB   = 4;
    localparam int CALN = 1000;
    localparam int XB   = 28;
    localparam int SC   = (25000 + 5000 - 1) / 5000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NE-1:0] engine_mask = '0;
    logic [NB-1:0] bank_mask = '0;
    logic          cal_en, clr_n, done;
    logic [NE-1:0] eng_sel;
    logic [NB-1:0] bank_upd;

    int checks = 0;
    int errors = 0;
    int prints = 0;
    longint cyc = 0;

    always #2.5 clk = ~clk;

    term_cal_seq u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .engine_mask (engine_mask),
        .bank_mask   (bank_mask),
        .cal_en      (cal_en),
        .clr_n       (clr_n),
        .eng_sel     (eng_sel),
        .bank_upd    (bank_upd),
        .done        (done)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 200000) begin
            $display("FAIL watchdog: run hung, actual cycle %0d expected below 200000", cyc);
            errors++;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            if (prints < 30) begin
                $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
                prints++;
            end
        end
    endtask

    task automatic expect_idle(input string req);
        chk(req, "cal_en", cal_en, 0);
        chk(req, "clr_n", clr_n, 1);
        chk(req, "eng_sel", eng_sel, 0);
        chk(req, "bank_upd", bank_upd, 0);
        chk(req, "done", done, 0);
    endtask

    // R11: reset state
    task automatic test_reset();
        @(negedge clk);
        expect_idle("R11");
        rst_n = 1'b1;
        @(negedge clk);
        expect_idle("R11");
    endtask

    // R1..R8, with optional mid-run pokes for R9 and R12
    task automatic run_seq(input logic [NE-1:0] em, input logic [NB-1:0] bm, input bit poke);
        int xs [NE];
        int ss [NB];
        int n = 0;
        int hi = -1;
        int f, c, d;
        for (int e = 0; e < NE; e++) begin
            xs[e] = -1;
            if (em[e]) begin
                xs[e] = 1003 + 29 * n;
                n++;
            end
        end
        for (int b = 0; b < NB; b++) begin
            ss[b] = -1;
            if (bm[b] && xs[b % NE] >= 0) begin
                ss[b] = xs[b % NE] + XB;
                if (ss[b] + SC - 1 > hi) hi = ss[b] + SC - 1;
            end
        end
        f = 1003 + 29 * n;
        c = (hi + 1 > f) ? hi + 1 : f;
        d = c + 1;

        @(negedge clk);
        start = 1'b1; engine_mask = em; bank_mask = bm;
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t <= d + 3; t++) begin
            logic          x_en, x_clr, x_done;
            logic [NE-1:0] x_sel;
            logic [NB-1:0] x_upd;
            x_en  = (t <= 1001);
            x_clr = (t != 0);
            x_sel = '0;
            if (t >= 1 && t <= CALN) x_sel = em;
            for (int e = 0; e < NE; e++)
                if (xs[e] >= 0 && t >= xs[e] && t < xs[e] + XB) x_sel[e] = 1'b1;
            for (int b = 0; b < NB; b++)
                x_upd[b] = (ss[b] >= 0 && t >= ss[b] && t < ss[b] + SC);
            x_done = (t == d);

            chk(poke ? "R1 R3 R9 R12" : (t == 0 ? "R1" : "R3"), "cal_en", cal_en, x_en);
            chk(poke ? "R1 R9" : "R1", "clr_n", clr_n, x_clr);
            if ((eng_sel & ~em) != 0)
                chk(poke ? "R5 R12" : "R5", "eng_sel", eng_sel, x_sel);
            else
                chk((t >= 1 && t <= CALN) ? "R2" : (poke ? "R4 R9" : "R4"), "eng_sel", eng_sel, x_sel);
            if ((bank_upd & ~x_upd & ~bm) != 0 || (bank_upd & ~x_upd) != 0 && x_upd == 0)
                chk(poke ? "R7 R12" : "R7", "bank_upd", bank_upd, x_upd);
            else
                chk(poke ? "R6 R12" : "R6", "bank_upd", bank_upd, x_upd);
            chk(poke ? "R8 R9" : "R8", "done", done, x_done);

            if (poke && t == 500) begin
                start = 1'b1; engine_mask = ~em; bank_mask = ~bm;
            end else if (poke && t == 1010) begin
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
    endtask

    // R10: empty engine mask is ignored
    task automatic test_empty_start();
        @(negedge clk);
        start = 1'b1; engine_mask = '0; bank_mask = '1;
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t < 20; t++) begin
            expect_idle("R10");
            @(negedge clk);
        end
    endtask

    initial begin
        test_reset();
        run_seq(4'b1111, 4'b1111, 1'b0);
        run_seq(4'b0101, 4'b0110, 1'b1);
        run_seq(4'b1000, 4'b0000, 1'b0);
        test_empty_start();
        run_seq(4'b0010, 4'b0010, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule